// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block is the in-order backbone of an out-of-order core. Instructions take an entry in issue order, and the entry index serves as the tag under which the instruction's result later returns. Results arrive out of order from the execution units. Entries leave strictly from the head, one at a time. Only a retiring entry touches architectural state: a register write, a store to memory, or nothing for a branch.

Values that have been produced but not yet retired can be read by tag through a lookup port, so that dependent instructions can pick them up before retirement. Two kinds of entry discard everything still held in the buffer. The first is a branch marked as mispredicted when its result came back. The second is an instruction that reported a fault. In both cases the action waits until the entry is at the head, so all older instructions have already retired and no younger one has. A fault suppresses the entry's own retirement and raises an exception pulse carrying its tag.

Top module: `reorder_buffer`

## Requirements
- R1: After reset the buffer is empty. `alloc_tag_o` is 0, and `commit_valid_o`, `flush_o`, `excp_o` and `lk_hit_o` are 0. `alloc_ready_o` is 1 whenever `rs_avail_i` is 1.
- R2: `alloc_ready_o` is 1 only when `rs_avail_i` is 1, the buffer holds fewer than DEPTH entries and no flush is being decided in that cycle. An allocation happens on a clock edge where `alloc_valid_i` and `alloc_ready_o` are both 1. It takes the tag shown on `alloc_tag_o`, and tags advance by one modulo DEPTH.
- R3: A result write (`wb_valid_i`) stores the value and the fault and mispredict flags in the entry named by `wb_tag_i`, and marks that entry ready. A write to a tag that holds no live entry is ignored.
- R4: At most one entry retires per cycle, and only the head entry, and only once it is ready. Retirement shows one cycle later as a one-cycle `commit_valid_o` pulse with the entry's kind, destination and value. No retirement happens while the head is not ready, whatever younger entries hold.
- R5: Kind encoding: 2'b00 is a register-writing operation (destination is a register number), 2'b01 is a store (destination is a memory address), and 2'b10 is a branch. A retiring branch drives `commit_dest_o` as 0.
- R6: A lookup presents `lk_tag_i`. One cycle later `lk_hit_o` is 1 and `lk_value_o` holds the stored value if the entry was live and ready. Otherwise `lk_hit_o` is 0, including after the entry has retired.
- R7: A branch written back with `wb_mispred_i` = 1 retires normally when it reaches the head, with `flush_o` = 1 in the same cycle. All entries are then discarded and the next tag is 0.
- R8: An entry written back with `wb_excp_i` = 1 has no visible effect until it reaches the head. There it raises `excp_o` and `flush_o` for one cycle, with `excp_tag_o` = its tag and `commit_valid_o` = 0. All entries are discarded and the next tag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rs_avail_i | input | 1 | A reservation station is free for the instruction being issued |
| alloc_valid_i | input | 1 | Issue request |
| alloc_kind_i | input | 2 | Instruction kind (R5 encoding) |
| alloc_dest_i | input | DEST_W | Register number or store address |
| alloc_ready_o | output | 1 | Allocation will be accepted this cycle |
| alloc_tag_o | output | TAG_W | Tag given to the next allocation |
| wb_valid_i | input | 1 | Result write strobe |
| wb_tag_i | input | TAG_W | Entry receiving the result |
| wb_value_i | input | DATA_W | Result value or store data |
| wb_excp_i | input | 1 | Instruction raised a fault |
| wb_mispred_i | input | 1 | Branch was mispredicted |
| lk_tag_i | input | TAG_W | Operand lookup tag |
| lk_hit_o | output | 1 | Looked-up entry was live and ready |
| lk_value_o | output | DATA_W | Looked-up value |
| commit_valid_o | output | 1 | An entry retired |
| commit_kind_o | output | 2 | Kind of the retired entry |
| commit_dest_o | output | DEST_W | Register number or store address (0 for a branch) |
| commit_value_o | output | DATA_W | Value to write or store |
| flush_o | output | 1 | All entries discarded |
| excp_o | output | 1 | Precise exception taken |
| excp_tag_o | output | TAG_W | Tag of the faulting entry |

## Verification
On every cycle the assertions check four things: tags advance by exactly one per accepted allocation, retirement and exception never coincide, every flush has a mispredicted branch or a fault as its cause, and the buffer is empty (next tag 0) whenever a flush is reported. Only the bench's scenarios can show the rest. These are the retirement order after results arrive out of order, the hold-off while the head is not ready, operand forwarding before and after retirement, wrap of the tags around the end of the buffer, and the deferral of a fault recorded in a younger entry.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    KIND_REG    = 2'd0,
    KIND_STORE  = 2'd1,
    KIND_BRANCH = 2'd2
  } kind_e;
endpackage

// File: rtl/rob_ptr.sv
// Head/tail pointers with an extra wrap bit to tell full from empty.
module rob_ptr #(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic          flush,
  output logic [IW-1:0] wr_idx,
  output logic [IW-1:0] rd_idx,
  output logic          full,
  output logic          empty
);
  logic [IW:0] wp, rp;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
    end
  end

  assign wr_idx = wp[IW-1:0];
  assign rd_idx = rp[IW-1:0];
  assign empty  = (wp == rp);
  assign full   = (wp[IW] != rp[IW]) && (wp[IW-1:0] == rp[IW-1:0]);
endmodule

// File: rtl/rob_store.sv
// Entry storage: per-entry flags in flops, payload in RAM-style arrays.
module rob_store
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int DEST_W = 32,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              alloc_en,
  input  logic [IW-1:0]     alloc_idx,
  input  kind_e             alloc_kind,
  input  logic [DEST_W-1:0] alloc_dest,
  input  logic              wb_en,
  input  logic [IW-1:0]     wb_idx,
  input  logic [DATA_W-1:0] wb_value,
  input  logic              wb_excp,
  input  logic              wb_mispred,
  input  logic              rel_en,
  input  logic [IW-1:0]     head_idx,
  output kind_e             head_kind,
  output logic [DEST_W-1:0] head_dest,
  output logic [DATA_W-1:0] head_value,
  output logic              head_excp,
  output logic              head_mispred,
  output logic              head_rdy,
  input  logic [IW-1:0]     lk_idx,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_value
);
  kind_e             kind_mem [DEPTH];
  logic [DEST_W-1:0] dest_mem [DEPTH];
  logic [DATA_W-1:0] val_mem  [DEPTH];

  logic [DEPTH-1:0] live, rdy, excp_v, mis_v;
  logic             wb_hit;

  assign wb_hit = wb_en && live[wb_idx];

  // Per-entry state bits
  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic alloc_me, wb_me, rel_me;
    assign alloc_me = alloc_en && (alloc_idx == IW'(g));
    assign wb_me    = wb_hit   && (wb_idx    == IW'(g));
    assign rel_me   = rel_en   && (head_idx  == IW'(g));

    always_ff @(posedge clk) begin
      if (rst || flush) begin
        live[g]   <= 1'b0;
        rdy[g]    <= 1'b0;
        excp_v[g] <= 1'b0;
        mis_v[g]  <= 1'b0;
      end else if (alloc_me) begin
        live[g]   <= 1'b1;
        rdy[g]    <= 1'b0;
        excp_v[g] <= 1'b0;
        mis_v[g]  <= 1'b0;
      end else if (wb_me) begin
        rdy[g]    <= 1'b1;
        excp_v[g] <= wb_excp;
        mis_v[g]  <= wb_mispred;
      end else if (rel_me) begin
        live[g]   <= 1'b0;
        rdy[g]    <= 1'b0;
      end
    end
  end

  // Payload arrays, no reset
  always_ff @(posedge clk) begin
    if (alloc_en) begin
      kind_mem[alloc_idx] <= alloc_kind;
      dest_mem[alloc_idx] <= alloc_dest;
    end
    if (wb_hit) val_mem[wb_idx] <= wb_value;
  end

  // Registered lookup port
  always_ff @(posedge clk) begin
    lk_value <= val_mem[lk_idx];
    if (rst) lk_hit <= 1'b0;
    else     lk_hit <= live[lk_idx] && rdy[lk_idx];
  end

  assign head_kind    = kind_mem[head_idx];
  assign head_dest    = dest_mem[head_idx];
  assign head_value   = val_mem[head_idx];
  assign head_excp    = excp_v[head_idx];
  assign head_mispred = mis_v[head_idx];
  assign head_rdy     = live[head_idx] && rdy[head_idx];
endmodule

// File: rtl/rob_retire.sv
// Head retirement decision and registered commit/flush outputs.
module rob_retire
  import rob_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEST_W = 32,
  parameter int IW     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              head_valid,
  input  logic              head_rdy,
  input  kind_e             head_kind,
  input  logic [DEST_W-1:0] head_dest,
  input  logic [DATA_W-1:0] head_value,
  input  logic              head_excp,
  input  logic              head_mispred,
  input  logic [IW-1:0]     head_idx,
  output logic              pop,
  output logic              flush_now,
  output logic              commit_valid_o,
  output logic [1:0]        commit_kind_o,
  output logic [DEST_W-1:0] commit_dest_o,
  output logic [DATA_W-1:0] commit_value_o,
  output logic              flush_o,
  output logic              excp_o,
  output logic [IW-1:0]     excp_tag_o
);
  logic go, br_redirect;

  assign go          = head_valid && head_rdy;
  assign br_redirect = (head_kind == KIND_BRANCH) && head_mispred;
  assign pop         = go && !head_excp;
  assign flush_now   = go && (head_excp || br_redirect);

  always_ff @(posedge clk) begin
    if (rst) begin
      commit_valid_o <= 1'b0;
      commit_kind_o  <= '0;
      commit_dest_o  <= '0;
      commit_value_o <= '0;
      flush_o        <= 1'b0;
      excp_o         <= 1'b0;
      excp_tag_o     <= '0;
    end else begin
      commit_valid_o <= pop;
      flush_o        <= flush_now;
      excp_o         <= go && head_excp;
      if (pop) begin
        commit_kind_o  <= head_kind;
        commit_dest_o  <= (head_kind == KIND_BRANCH) ? '0 : head_dest;
        commit_value_o <= head_value;
      end
      if (go && head_excp) excp_tag_o <= head_idx;
    end
  end
endmodule

// File: rtl/reorder_buffer.sv
module reorder_buffer
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int DEST_W = 32,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rs_avail_i,
  input  logic              alloc_valid_i,
  input  logic [1:0]        alloc_kind_i,
  input  logic [DEST_W-1:0] alloc_dest_i,
  output logic              alloc_ready_o,
  output logic [TAG_W-1:0]  alloc_tag_o,
  input  logic              wb_valid_i,
  input  logic [TAG_W-1:0]  wb_tag_i,
  input  logic [DATA_W-1:0] wb_value_i,
  input  logic              wb_excp_i,
  input  logic              wb_mispred_i,
  input  logic [TAG_W-1:0]  lk_tag_i,
  output logic              lk_hit_o,
  output logic [DATA_W-1:0] lk_value_o,
  output logic              commit_valid_o,
  output logic [1:0]        commit_kind_o,
  output logic [DEST_W-1:0] commit_dest_o,
  output logic [DATA_W-1:0] commit_value_o,
  output logic              flush_o,
  output logic              excp_o,
  output logic [TAG_W-1:0]  excp_tag_o
);
  logic             full, empty, pop, flush_now, alloc_fire;
  logic [TAG_W-1:0] head_idx;
  kind_e            head_kind;
  logic [DEST_W-1:0] head_dest;
  logic [DATA_W-1:0] head_value;
  logic             head_excp, head_mispred, head_rdy;

  assign alloc_ready_o = rs_avail_i && !full && !flush_now;
  assign alloc_fire    = alloc_valid_i && alloc_ready_o;

  rob_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk    (clk),
    .rst    (rst),
    .push   (alloc_fire),
    .pop    (pop),
    .flush  (flush_now),
    .wr_idx (alloc_tag_o),
    .rd_idx (head_idx),
    .full   (full),
    .empty  (empty)
  );

  rob_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DEST_W(DEST_W)) u_store (
    .clk          (clk),
    .rst          (rst),
    .flush        (flush_now),
    .alloc_en     (alloc_fire),
    .alloc_idx    (alloc_tag_o),
    .alloc_kind   (kind_e'(alloc_kind_i)),
    .alloc_dest   (alloc_dest_i),
    .wb_en        (wb_valid_i),
    .wb_idx       (wb_tag_i),
    .wb_value     (wb_value_i),
    .wb_excp      (wb_excp_i),
    .wb_mispred   (wb_mispred_i),
    .rel_en       (pop),
    .head_idx     (head_idx),
    .head_kind    (head_kind),
    .head_dest    (head_dest),
    .head_value   (head_value),
    .head_excp    (head_excp),
    .head_mispred (head_mispred),
    .head_rdy     (head_rdy),
    .lk_idx       (lk_tag_i),
    .lk_hit       (lk_hit_o),
    .lk_value     (lk_value_o)
  );

  rob_retire #(.DATA_W(DATA_W), .DEST_W(DEST_W), .IW(TAG_W)) u_retire (
    .clk            (clk),
    .rst            (rst),
    .head_valid     (!empty),
    .head_rdy       (head_rdy),
    .head_kind      (head_kind),
    .head_dest      (head_dest),
    .head_value     (head_value),
    .head_excp      (head_excp),
    .head_mispred   (head_mispred),
    .head_idx       (head_idx),
    .pop            (pop),
    .flush_now      (flush_now),
    .commit_valid_o (commit_valid_o),
    .commit_kind_o  (commit_kind_o),
    .commit_dest_o  (commit_dest_o),
    .commit_value_o (commit_value_o),
    .flush_o        (flush_o),
    .excp_o         (excp_o),
    .excp_tag_o     (excp_tag_o)
  );
endmodule

// File: rtl/reorder_buffer_chk.sv
module reorder_buffer_chk #(
  parameter int TAG_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             alloc_valid_i,
  input logic             alloc_ready_o,
  input logic [TAG_W-1:0] alloc_tag_o,
  input logic             commit_valid_o,
  input logic [1:0]       commit_kind_o,
  input logic             flush_o,
  input logic             excp_o
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!commit_valid_o && !flush_o && !excp_o && alloc_tag_o == '0));

  // R2
  tag_step_chk: assert property (@(posedge clk) disable iff (rst)
    (alloc_valid_i && alloc_ready_o) |=> (alloc_tag_o == TAG_W'($past(alloc_tag_o) + 1'b1)));

  // R4
  commit_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(commit_valid_o && excp_o));

  // R7
  flush_cause_chk: assert property (@(posedge clk) disable iff (rst)
    flush_o |-> (excp_o || (commit_valid_o && commit_kind_o == 2'd2)));

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    flush_o |-> (alloc_tag_o == '0));
endmodule

bind reorder_buffer reorder_buffer_chk #(.TAG_W(TAG_W)) u_rob_chk (
  .clk            (clk),
  .rst            (rst),
  .alloc_valid_i  (alloc_valid_i),
  .alloc_ready_o  (alloc_ready_o),
  .alloc_tag_o    (alloc_tag_o),
  .commit_valid_o (commit_valid_o),
  .commit_kind_o  (commit_kind_o),
  .flush_o        (flush_o),
  .excp_o         (excp_o)
);

// File: tb/test_reorder_buffer.sv
`timescale 1ns/1ps
module test_reorder_buffer;
  localparam int D = 8;
  localparam int TW = 3;

  logic clk = 0, rst = 1;
  logic rs_avail_i = 1, alloc_valid_i = 0;
  logic [1:0] alloc_kind_i = 0;
  logic [31:0] alloc_dest_i = 0;
  logic alloc_ready_o;
  logic [TW-1:0] alloc_tag_o;
  logic wb_valid_i = 0, wb_excp_i = 0, wb_mispred_i = 0;
  logic [TW-1:0] wb_tag_i = 0, lk_tag_i = 0;
  logic [31:0] wb_value_i = 0;
  logic lk_hit_o;
  logic [31:0] lk_value_o;
  logic commit_valid_o, flush_o, excp_o;
  logic [1:0] commit_kind_o;
  logic [31:0] commit_dest_o, commit_value_o;
  logic [TW-1:0] excp_tag_o;

  always #2 clk = ~clk;

  reorder_buffer i_reorder_buffer (
    .clk(clk), .rst(rst), .rs_avail_i(rs_avail_i), .alloc_valid_i(alloc_valid_i),
    .alloc_kind_i(alloc_kind_i), .alloc_dest_i(alloc_dest_i), .alloc_ready_o(alloc_ready_o),
    .alloc_tag_o(alloc_tag_o), .wb_valid_i(wb_valid_i), .wb_tag_i(wb_tag_i),
    .wb_value_i(wb_value_i), .wb_excp_i(wb_excp_i), .wb_mispred_i(wb_mispred_i),
    .lk_tag_i(lk_tag_i), .lk_hit_o(lk_hit_o), .lk_value_o(lk_value_o),
    .commit_valid_o(commit_valid_o), .commit_kind_o(commit_kind_o),
    .commit_dest_o(commit_dest_o), .commit_value_o(commit_value_o),
    .flush_o(flush_o), .excp_o(excp_o), .excp_tag_o(excp_tag_o));

  typedef struct {
    logic [1:0]  kind;
    logic [31:0] dest;
    logic [31:0] val;
    bit          excp;
    bit          mis;
    int          tag;
  } exp_t;

  exp_t q[$];
  logic [31:0] tv[D];
  bit te[D], tm[D];
  int n_chk = 0, n_bad = 0;
  int n_commit = 0, n_excp = 0, n_flush = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: compare retirements against the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (commit_valid_o) n_commit++;
      if (excp_o) n_excp++;
      if (flush_o) n_flush++;
      if (commit_valid_o || excp_o) begin
        if (q.size() == 0) begin
          chk(0, "R4 unexpected retirement", 64'(commit_value_o), 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (e.excp) begin
            chk(excp_o == 1'b1, "R8 excp_o", 64'(excp_o), 1);
            chk(commit_valid_o == 1'b0, "R8 no commit", 64'(commit_valid_o), 0);
            chk(flush_o == 1'b1, "R8 flush_o", 64'(flush_o), 1);
            chk(excp_tag_o == TW'(e.tag), "R8 excp_tag", 64'(excp_tag_o), 64'(e.tag));
            q.delete();
          end else begin
            chk(commit_valid_o == 1'b1, "R4 commit_valid", 64'(commit_valid_o), 1);
            chk(commit_kind_o == e.kind, "R5 kind", 64'(commit_kind_o), 64'(e.kind));
            chk(commit_dest_o == ((e.kind == 2'd2) ? 32'd0 : e.dest), "R5 dest",
                64'(commit_dest_o), 64'((e.kind == 2'd2) ? 32'd0 : e.dest));
            chk(commit_value_o == e.val, "R4 value", 64'(commit_value_o), 64'(e.val));
            if (e.mis) begin
              chk(flush_o == 1'b1, "R7 flush on mispredict", 64'(flush_o), 1);
              q.delete();
            end else begin
              chk(flush_o == 1'b0, "R7 no flush", 64'(flush_o), 0);
            end
          end
        end
      end
    end
  end

  // Driver: allocate one entry and push its expected retirement
  task automatic do_alloc(input logic [1:0] k, input logic [31:0] dst, input logic [31:0] v,
                          input bit ex, input bit mp, input int exp_tag);
    exp_t e;
    chk(alloc_ready_o == 1'b1, "R2 ready before alloc", 64'(alloc_ready_o), 1);
    chk(alloc_tag_o == TW'(exp_tag), "R2 tag", 64'(alloc_tag_o), 64'(exp_tag));
    alloc_valid_i = 1; alloc_kind_i = k; alloc_dest_i = dst;
    e.kind = k; e.dest = dst; e.val = v; e.excp = ex; e.mis = mp; e.tag = int'(alloc_tag_o);
    tv[alloc_tag_o] = v; te[alloc_tag_o] = ex; tm[alloc_tag_o] = mp;
    q.push_back(e);
    @(posedge clk); #1;
    alloc_valid_i = 0;
  endtask

  task automatic do_wb(input int t);
    wb_valid_i = 1; wb_tag_i = TW'(t); wb_value_i = tv[t]; wb_excp_i = te[t]; wb_mispred_i = tm[t];
    @(posedge clk); #1;
    wb_valid_i = 0; wb_excp_i = 0; wb_mispred_i = 0;
  endtask

  task automatic do_lk(input int t, output logic hit, output logic [31:0] v);
    lk_tag_i = TW'(t);
    @(posedge clk);
    @(negedge clk);
    hit = lk_hit_o; v = lk_value_o;
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic hit;
    logic [31:0] v;
    int base, c0, x0, f0;

    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(alloc_ready_o == 1'b1, "R1 ready", 64'(alloc_ready_o), 1);
    chk(alloc_tag_o == '0, "R1 tag", 64'(alloc_tag_o), 0);
    chk(!commit_valid_o && !flush_o && !excp_o, "R1 outputs quiet",
        64'({commit_valid_o, flush_o, excp_o}), 0);
    chk(lk_hit_o == 1'b0, "R1 lookup", 64'(lk_hit_o), 0);
    #1;

    // R2 no reservation station
    rs_avail_i = 0; #1;
    chk(alloc_ready_o == 1'b0, "R2 no station", 64'(alloc_ready_o), 0);
    rs_avail_i = 1; #1;

    // Phase A: out-of-order results, in-order retirement (R3, R4)
    do_alloc(2'd0, 32'd5, 32'h11, 0, 0, 0);
    do_alloc(2'd1, 32'h100, 32'h22, 0, 0, 1);
    do_alloc(2'd0, 32'd7, 32'h33, 0, 0, 2);
    do_wb(2); do_wb(0); do_wb(1);
    idle(6);
    chk(n_commit == 3 && q.size() == 0, "R4 phase A drained", 64'(n_commit), 3);

    // R3: write to a free tag is ignored
    tv[5] = 32'hbad; te[5] = 0; tm[5] = 0;
    do_wb(5);
    do_lk(5, hit, v);
    chk(hit == 1'b0, "R3 write to free tag ignored", 64'(hit), 0);
    idle(3);
    chk(n_commit == 3, "R3 no retirement from free tag", 64'(n_commit), 3);

    // Phase B: fill with wrap, hold-off while head not ready (R2, R4, R5, R6)
    base = 3;
    for (int i = 0; i < D; i++) begin
      logic [1:0] k;
      k = 2'(i % 3);
      do_alloc(k, 32'h40 + 32'(i) + ((k == 2'd2) ? 32'hdead0000 : 32'd0),
               32'h1000 + 32'(i), 0, 0, (base + i) % D);
    end
    chk(alloc_ready_o == 1'b0, "R2 full blocks", 64'(alloc_ready_o), 0);
    do_lk(base, hit, v);
    chk(hit == 1'b0, "R6 not ready misses", 64'(hit), 0);
    c0 = n_commit;
    for (int i = D - 1; i >= 1; i--) do_wb((base + i) % D);
    idle(4);
    chk(n_commit == c0, "R4 head not ready holds", 64'(n_commit), 64'(c0));
    do_lk((base + 4) % D, hit, v);
    chk(hit == 1'b1, "R6 ready hit", 64'(hit), 1);
    chk(v == 32'h1004, "R6 forwarded value", 64'(v), 64'h1004);
    do_wb(base);
    idle(12);
    chk(n_commit == c0 + D && q.size() == 0, "R4 phase B drained", 64'(n_commit), 64'(c0 + D));
    do_lk((base + 4) % D, hit, v);
    chk(hit == 1'b0, "R6 retired misses", 64'(hit), 0);

    // Phase C: mispredicted branch flushes younger entries (R7)
    base = int'(alloc_tag_o);
    f0 = n_flush;
    do_alloc(2'd0, 32'd1, 32'h501, 0, 0, base);
    do_alloc(2'd2, 32'd0, 32'h502, 0, 1, (base + 1) % D);
    do_alloc(2'd0, 32'd3, 32'h503, 0, 0, (base + 2) % D);
    do_alloc(2'd1, 32'h200, 32'h504, 0, 0, (base + 3) % D);
    do_alloc(2'd0, 32'd4, 32'h505, 0, 0, (base + 4) % D);
    for (int i = 4; i >= 0; i--) do_wb((base + i) % D);
    idle(10);
    chk(n_flush == f0 + 1, "R7 one flush", 64'(n_flush), 64'(f0 + 1));
    chk(alloc_tag_o == '0, "R7 tag reset", 64'(alloc_tag_o), 0);
    do_lk((base + 2) % D, hit, v);
    chk(hit == 1'b0, "R7 flushed entry gone", 64'(hit), 0);

    // Phase D: deferred precise exception (R8)
    c0 = n_commit; x0 = n_excp;
    do_alloc(2'd0, 32'd8, 32'h601, 0, 0, 0);
    do_alloc(2'd0, 32'd9, 32'h602, 1, 0, 1);
    do_alloc(2'd1, 32'h300, 32'h603, 0, 0, 2);
    do_alloc(2'd0, 32'd10, 32'h604, 0, 0, 3);
    do_wb(3); do_wb(2); do_wb(1);
    idle(5);
    chk(n_excp == x0 && n_commit == c0, "R8 fault deferred", 64'(n_excp), 64'(x0));
    do_wb(0);
    idle(8);
    chk(n_excp == x0 + 1, "R8 exception taken", 64'(n_excp), 64'(x0 + 1));
    chk(n_commit == c0 + 1, "R8 only older retired", 64'(n_commit), 64'(c0 + 1));
    chk(alloc_tag_o == '0 && q.size() == 0, "R8 buffer emptied", 64'(alloc_tag_o), 0);

    finish_run();
  end
endmodule